// File: doc/BRIEF.md
# Interrupt-Aware Fetch Sequencer

This block is the fetch controller of a small 12-bit processor. Each time the execute side asks for a new instruction, the block runs one of two fetch sequences. It steps through the sequence one clock per step and drives the memory read, instruction-register load, incrementer load, PC load, PC-to-address select and stack push strobes. It also holds the program counter, the incrementer register, the instruction register and the interrupt-enable flag.

A normal fetch puts the PC on the address bus. It latches the memory word into the instruction register, then captures PC+1 in the incrementer register, then writes that value back into the PC. If an interrupt request is present and interrupts are enabled when a fetch begins, an interrupt fetch runs instead. It first masks further interrupts, then pushes the current PC onto the stack, then loads a fixed vector address into the PC, and then performs the normal fetch steps from that vector. Interrupts come back on only through a dedicated re-enable input, which the service routine drives after it has restored the PC.

A one-cycle done pulse in the final step hands control to the execute stage.

Top module: `irq_fetch_seq`

## Requirements
- R1: While reset is asserted and after it is released, pc_o, ir_o and int_en_o are zero and every strobe output and done_o is low.
- R2: When start_i is sampled in idle and no interrupt is taken, a normal fetch lasts exactly three cycles. Cycle 1 asserts mem_rd_o, ir_load_o and pc_sel_o. Cycle 2 asserts inc_load_o and pc_sel_o. Cycle 3 asserts pc_load_o and done_o. Afterwards ir_o holds the memory word at the old PC, and pc_o equals the old PC plus one, modulo 2^ADDR_W.
- R3: An interrupt fetch runs exactly when irq_i and int_en_o are both high in the cycle where start_i is accepted.
- R4: The first cycle of an interrupt fetch asserts no strobe and clears the interrupt enable. From the second cycle on, int_en_o is low, even if irq_reenable_i was high in that first cycle.
- R5: The second cycle of an interrupt fetch asserts push_o alone, with push_data_o equal to the PC held when the fetch started.
- R6: The third cycle of an interrupt fetch asserts pc_load_o alone and loads the parameter VECTOR into the PC. Cycles 4 to 6 then repeat the three normal-fetch cycles from VECTOR. The fetch ends with ir_o holding the word at VECTOR and pc_o at VECTOR+1.
- R7: irq_i has no effect while int_en_o is low, and a change of irq_i after the start cycle does not alter the running sequence.
- R8: A high irq_reenable_i sets int_en_o at the next edge, except during the mask cycle. int_en_o never rises without it.
- R9: done_o is a single-cycle pulse, and at most one of push_o, ir_load_o, inc_load_o and done_o is high in any cycle.
- R10: addr_o equals pc_o while pc_sel_o is high and is zero otherwise.
- R11: start_i is ignored while a fetch is in progress; after the final cycle the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a fetch (accepted in idle) |
| irq_i | input | 1 | Interrupt request |
| irq_reenable_i | input | 1 | Set interrupt enable |
| mem_data_i | input | DATA_W | Memory read data |
| addr_o | output | ADDR_W | Address bus (PC when selected) |
| mem_rd_o | output | 1 | Memory read strobe |
| ir_load_o | output | 1 | Instruction register load strobe |
| inc_load_o | output | 1 | Incrementer register load strobe |
| pc_load_o | output | 1 | PC load strobe |
| pc_sel_o | output | 1 | PC drives address bus |
| push_o | output | 1 | Stack push strobe |
| push_data_o | output | ADDR_W | Value pushed (current PC) |
| ir_o | output | DATA_W | Instruction register |
| pc_o | output | ADDR_W | Program counter |
| int_en_o | output | 1 | Interrupt enable flag |
| done_o | output | 1 | Fetch complete, hand-off to execute |

## Verification
The assertions check on every cycle that the strobes are mutually exclusive and that done is a single pulse. They also check that a push always carries the current PC with interrupts already masked, that the vector reaches the PC two cycles after a push, that a completed fetch advances the PC by one, and that the interrupt enable rises only after a re-enable. Only the bench's scenarios can show the choice between the two sequences as a function of the request and enable at the start cycle. The same holds for the exact step order and cycle counts, the mask winning over a simultaneous re-enable, requests changing mid-fetch being ignored, start being ignored while busy, and PC wrap past the top of the address space.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_INC  = 3'd2,
    ST_WB   = 3'd3,
    ST_MASK = 3'd4,
    ST_PUSH = 3'd5,
    ST_VEC  = 3'd6
  } fseq_state_e;
endpackage

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fetch_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic irq_i,
  input  logic int_en_i,
  output logic mem_rd_o,
  output logic ir_load_o,
  output logic inc_load_o,
  output logic pc_load_o,
  output logic vec_load_o,
  output logic pc_sel_o,
  output logic push_o,
  output logic ie_clr_o,
  output logic done_o
);
  fseq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = (irq_i && int_en_i) ? ST_MASK : ST_RD;
      ST_MASK: state_d = ST_PUSH;
      ST_PUSH: state_d = ST_VEC;
      ST_VEC:  state_d = ST_RD;
      ST_RD:   state_d = ST_INC;
      ST_INC:  state_d = ST_WB;
      ST_WB:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign mem_rd_o   = (state_q == ST_RD);
  assign ir_load_o  = (state_q == ST_RD);
  assign inc_load_o = (state_q == ST_INC);
  assign pc_sel_o   = (state_q == ST_RD) || (state_q == ST_INC);
  assign vec_load_o = (state_q == ST_VEC);
  assign pc_load_o  = (state_q == ST_VEC) || (state_q == ST_WB);
  assign push_o     = (state_q == ST_PUSH);
  assign ie_clr_o   = (state_q == ST_MASK);
  assign done_o     = (state_q == ST_WB);
endmodule

// File: rtl/fseq_pc_path.sv
module fseq_pc_path #(
  parameter int unsigned          ADDR_W = 12,
  parameter logic [ADDR_W-1:0]    VECTOR = 12'h010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_load_i,
  input  logic              pc_load_i,
  input  logic              vec_load_i,
  input  logic              pc_sel_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] pc_o
);
  logic [ADDR_W-1:0] pc_q, inc_q, pc_d;

  // incrementer sees the address bus, not the PC directly
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         inc_q <= '0;
    else if (inc_load_i) inc_q <= addr_o + 1'b1;
  end

  assign pc_d = vec_load_i ? VECTOR : inc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pc_q <= '0;
    else if (pc_load_i) pc_q <= pc_d;
  end

  assign addr_o = pc_sel_i ? pc_q : '0;
  assign pc_o   = pc_q;
endmodule

// File: rtl/fseq_regs.sv
module fseq_regs #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ir_load_i,
  input  logic [DATA_W-1:0] mem_data_i,
  input  logic              ie_set_i,
  input  logic              ie_clr_i,
  output logic [DATA_W-1:0] ir_o,
  output logic              int_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ir_o <= '0;
    else if (ir_load_i) ir_o <= mem_data_i;
  end

  // masking wins over a simultaneous re-enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       int_en_o <= 1'b0;
    else if (ie_clr_i) int_en_o <= 1'b0;
    else if (ie_set_i) int_en_o <= 1'b1;
  end
endmodule

// File: rtl/irq_fetch_seq.sv
module irq_fetch_seq #(
  parameter int unsigned       ADDR_W = 12,
  parameter int unsigned       DATA_W = 12,
  parameter logic [ADDR_W-1:0] VECTOR = 12'h010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              irq_i,
  input  logic              irq_reenable_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              mem_rd_o,
  output logic              ir_load_o,
  output logic              inc_load_o,
  output logic              pc_load_o,
  output logic              pc_sel_o,
  output logic              push_o,
  output logic [ADDR_W-1:0] push_data_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              int_en_o,
  output logic              done_o
);
  logic vec_load, ie_clr;

  fseq_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .irq_i      (irq_i),
    .int_en_i   (int_en_o),
    .mem_rd_o   (mem_rd_o),
    .ir_load_o  (ir_load_o),
    .inc_load_o (inc_load_o),
    .pc_load_o  (pc_load_o),
    .vec_load_o (vec_load),
    .pc_sel_o   (pc_sel_o),
    .push_o     (push_o),
    .ie_clr_o   (ie_clr),
    .done_o     (done_o)
  );

  fseq_pc_path #(.ADDR_W(ADDR_W), .VECTOR(VECTOR)) u_pc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_load_i (inc_load_o),
    .pc_load_i  (pc_load_o),
    .vec_load_i (vec_load),
    .pc_sel_i   (pc_sel_o),
    .addr_o     (addr_o),
    .pc_o       (pc_o)
  );

  fseq_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ir_load_i  (ir_load_o),
    .mem_data_i (mem_data_i),
    .ie_set_i   (irq_reenable_i),
    .ie_clr_i   (ie_clr),
    .ir_o       (ir_o),
    .int_en_o   (int_en_o)
  );

  assign push_data_o = pc_o;
endmodule

// File: rtl/irq_fetch_seq_chk.sv
module irq_fetch_seq_chk #(
  parameter int unsigned       ADDR_W = 12,
  parameter int unsigned       DATA_W = 12,
  parameter logic [ADDR_W-1:0] VECTOR = 12'h010
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_reenable_i,
  input logic [DATA_W-1:0] mem_data_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              ir_load_o,
  input logic              inc_load_o,
  input logic              pc_sel_o,
  input logic              push_o,
  input logic [ADDR_W-1:0] push_data_o,
  input logic [DATA_W-1:0] ir_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic              int_en_o,
  input logic              done_o
);
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({push_o, ir_load_o, inc_load_o, done_o}));  // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R9
  AST_PUSH_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> !int_en_o);  // R4
  AST_PUSH_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> (push_data_o == pc_o));  // R5
  AST_VECTOR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> ##1 (pc_o == VECTOR));  // R6
  AST_IR_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_load_o |=> (ir_o == $past(mem_data_i)));  // R2
  AST_PC_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (pc_o == ADDR_W'($past(pc_o) + 1'b1)));  // R2
  AST_IE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_en_o) |-> $past(irq_reenable_i));  // R8
  AST_ADDR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_sel_o |-> (addr_o == '0));  // R10
endmodule

bind irq_fetch_seq irq_fetch_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VECTOR(VECTOR)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .irq_reenable_i (irq_reenable_i),
  .mem_data_i     (mem_data_i),
  .addr_o         (addr_o),
  .ir_load_o      (ir_load_o),
  .inc_load_o     (inc_load_o),
  .pc_sel_o       (pc_sel_o),
  .push_o         (push_o),
  .push_data_o    (push_data_o),
  .ir_o           (ir_o),
  .pc_o           (pc_o),
  .int_en_o       (int_en_o),
  .done_o         (done_o)
);

// File: tb/irq_fetch_seq_bench.sv
module irq_fetch_seq_bench;
  localparam int          CLK_PERIOD = 10;
  localparam int          AW = 12;
  localparam int          DW = 12;
  localparam logic [11:0] VEC = 12'hFFE;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, irq = 1'b0, reen = 1'b0;
  logic [DW-1:0] mem_data;
  logic [AW-1:0] addr, push_data, pc;
  logic [DW-1:0] ir;
  logic          mem_rd, ir_load, inc_load, pc_load, pc_sel, push, int_en, done;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [AW-1:0] m_pc = '0;
  logic          m_ie = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return (a ^ 12'h5A3) + {a[3:0], 8'h00};
  endfunction

  assign mem_data = mem_word(addr);

  irq_fetch_seq #(.ADDR_W(AW), .DATA_W(DW), .VECTOR(VEC)) u_irq_fetch_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .irq_i(irq),
    .irq_reenable_i(reen), .mem_data_i(mem_data), .addr_o(addr),
    .mem_rd_o(mem_rd), .ir_load_o(ir_load), .inc_load_o(inc_load),
    .pc_load_o(pc_load), .pc_sel_o(pc_sel), .push_o(push),
    .push_data_o(push_data), .ir_o(ir), .pc_o(pc), .int_en_o(int_en),
    .done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [6:0] strobes();
    return {mem_rd, ir_load, inc_load, pc_load, pc_sel, push, done};
  endfunction

  // step codes: 0 RD,1 INC,2 WB,3 MASK,4 PUSH,5 VEC
  function automatic logic [6:0] exp_strobes(input int s);
    case (s)
      0: return 7'b1100100;
      1: return 7'b0010100;
      2: return 7'b0001001;
      4: return 7'b0000010;
      5: return 7'b0001000;
      default: return 7'b0000000;
    endcase
  endfunction

  // called at an idle negedge
  task automatic run_fetch(input bit rq, input bit rq_flip, input bit reen_mid, input bit start_busy);
    bit take;
    int n;
    logic [AW-1:0] old_pc, cur_pc;
    string tag;
    take   = rq && m_ie;
    old_pc = m_pc;
    n      = take ? 6 : 3;
    start = 1'b1; irq = rq;
    for (int k = 0; k < n; k++) begin
      int s;
      @(negedge clk);
      if (k == 0) begin
        start = start_busy; irq = rq_flip ? ~rq : rq; reen = reen_mid;
      end else begin
        reen = 1'b0;
        if (k == n-1) start = 1'b0;
      end
      s = take ? (k < 3 ? k + 3 : k - 3) : k;
      cur_pc = (take && k >= 3) ? VEC : old_pc;
      tag = take ? ((s == 4) ? "R5" : "R6") : ((rq && !m_ie) ? "R7" : "R2");
      chk(strobes() == exp_strobes(s), tag, strobes(), exp_strobes(s));
      chk(addr == (pc_sel ? cur_pc : '0), "R10", addr, pc_sel ? cur_pc : 0);
      if (take && k == 1) begin
        chk(int_en == 1'b0, "R4", int_en, 0);
        chk(push_data == old_pc, "R5", push_data, old_pc);
      end
      if (take && k == 3) chk(pc == VEC, "R6", pc, VEC);
    end
    if (take) m_ie = 1'b0;
    else if (reen_mid) m_ie = 1'b1;
    cur_pc = take ? VEC : old_pc;
    m_pc = cur_pc + 1'b1;
    @(negedge clk);
    tag = start_busy ? "R11" : (take ? "R3" : "R2");
    chk(strobes() == 7'b0, tag, strobes(), 0);
    chk(pc == m_pc, take ? "R6" : "R2", pc, m_pc);
    chk(ir == mem_word(cur_pc), take ? "R6" : "R2", ir, mem_word(cur_pc));
    chk(int_en == m_ie, take ? "R4" : "R8", int_en, m_ie);
  endtask

  task automatic reenable_idle();
    reen = 1'b1;
    @(negedge clk);
    reen = 1'b0;
    m_ie = 1'b1;
    chk(int_en == 1'b1, "R8", int_en, 1);
    chk(strobes() == 7'b0, "R8", strobes(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(pc == '0 && ir == '0 && !int_en, "R1", {pc, ir}, 0);
    chk(strobes() == 7'b0, "R1", strobes(), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pc == '0 && ir == '0 && !int_en && strobes() == 7'b0, "R1", {pc, ir}, 0);
    // irq with enable low at reset: normal fetch
    run_fetch(1'b1, 1'b0, 1'b0, 1'b0);  // R7
    for (int i = 0; i < 400; i++) begin
      if (i % 7 == 3) reenable_idle();
      run_fetch(i[0] | i[3], i[1], (i % 5 == 2), i[2]);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule